// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM that accepts a new read or write command on every active clock edge, in any mix, with no idle cycles inserted when the traffic changes direction. Address, write enable, chip enables and per-lane write selects are all registered on the rising clock edge. A read returns its word through an output register. A write takes its data from the write-data input two active edges after the command. The read data therefore occupies the same bus window that a write in the same slot would use.

A write stays posted in a short address pipeline until its data arrives. A read that follows such a write to the same address gets the newer bytes, merged lane by lane. A clock enable freezes the whole pipeline. Three chip enables qualify each command. An asynchronous output enable gates the output drive on top of the internal synchronous drive control. The model uses a small array in place of a full memory.

Top module: `nturn_sram`

## Requirements
- R1: While `rstN` is low, all pipeline state is cleared, the output drive is off and every array word becomes zero.
- R2: Address, `weN`, the chip enables and `byteWeN` are sampled only at a rising edge of `clk` at which `cenN` is low.
- R3: A read command sampled at active edge k drives `rdDrive` high and places the addressed word on `rdData` from edge k+1 until the next active edge.
- R4: For a write command sampled at active edge k, the array is written with the value that `wrData` holds at active edge k+2.
- R5: `byteWeN` is active low, with one bit per 9-bit lane. Bit i controls `wrData[9i+8:9i]`. A lane whose bit is high keeps its old contents.
- R6: A command counts as selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0. Otherwise it is a deselect, which writes nothing, returns nothing and does not disturb writes already pending.
- R7: Reads and writes in any order run on consecutive active edges with no idle cycles.
- R8: `rdDrive` is low during the data phase of a write and during the data phase of a deselect.
- R9: At an edge where `cenN` is high, no input is taken, including `wrData`. Pipeline state, array contents, `rdData` and `rdDrive` stay unchanged.
- R10: A read issued on the active edge right after a write to the same address returns the new data in the enabled lanes and the older array data in the other lanes.
- R11: `oeN` high forces `rdDrive` low combinationally. It has no effect on the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cenN | input | 1 | Active-low clock enable; high stalls the block |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| weN | input | 1 | Low = write command, high = read command |
| addr | input | ADDR_W | Word address |
| byteWeN | input | LANES | Active-low write select per lane |
| oeN | input | 1 | Asynchronous active-low output enable |
| wrData | input | LANES*LANE_W | Write data, taken two active edges after its command |
| rdData | output | LANES*LANE_W | Registered read data |
| rdDrive | output | 1 | High when the block drives the data bus |

## Verification
The bench runs several command patterns:
- Full-word writes followed by reads, to isolate the latency of the two paths.
- Alternating write and read to one address, which separates a design that forwards pending data from one that returns stale array contents.
- Random byte masks, to expose lane mix-ups in the array and in the forwarding path.
- Random deselects and random clock-enable stalls, which show whether a deselect or a stall wrongly advances, drops or re-samples a pending write. The stalls change `wrData` while the clock is disabled.
- Toggling the output enable, which checks that it gates the drive without touching the pipeline.

// File: rtl/nturn_sram_pkg.sv
package nturn_sram_pkg;

  // Strobes from the command pipeline to the storage datapath
  typedef struct packed {
    logic advance;      // active edge: pipeline moves
    logic commitWrite;  // oldest stage is a write whose data is on wrData now
    logic loadRead;     // youngest stage is a read: load the output register
    logic fwdHit;       // read address equals the pending write address
  } sramStrobe_t;

endpackage

// File: rtl/nturn_sram_ctrl.sv
module nturn_sram_ctrl
  import nturn_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cenN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteWeN,
  output sramStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LANES-1:0]  wrMask,
  output logic              driveSync
);

  // Two registers carry a write address until its data arrives
  localparam int STAGES = 2;
  localparam int LAST   = STAGES - 1;

  logic              stgValid [STAGES];
  logic              stgWrite [STAGES];
  logic [ADDR_W-1:0] stgAddr  [STAGES];
  logic [LANES-1:0]  stgMask  [STAGES];

  logic selected;
  logic advance;

  assign selected = !ce1N && ce2 && !ce3N;
  assign advance  = !cenN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) begin
        stgValid[s] <= 1'b0;
        stgWrite[s] <= 1'b0;
        stgAddr[s]  <= '0;
        stgMask[s]  <= '0;
      end
      driveSync <= 1'b0;
    end else if (advance) begin
      stgValid[0] <= selected;
      stgWrite[0] <= !weN;
      stgAddr[0]  <= addr;
      stgMask[0]  <= ~byteWeN;
      for (int s = 1; s < STAGES; s++) begin
        stgValid[s] <= stgValid[s-1];
        stgWrite[s] <= stgWrite[s-1];
        stgAddr[s]  <= stgAddr[s-1];
        stgMask[s]  <= stgMask[s-1];
      end
      driveSync <= stgValid[0] && !stgWrite[0];
    end
  end

  assign wrAddr = stgAddr[LAST];
  assign rdAddr = stgAddr[0];
  assign wrMask = stgMask[LAST];

  always_comb begin
    strobe.advance     = advance;
    strobe.commitWrite = advance && stgValid[LAST] && stgWrite[LAST];
    strobe.loadRead    = advance && stgValid[0] && !stgWrite[0];
    strobe.fwdHit      = stgValid[LAST] && stgWrite[LAST] && (stgAddr[LAST] == stgAddr[0]);
  end

  // R9: a stalled edge changes no pipeline state
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    cenN |=> $stable(stgValid[0]) && $stable(stgAddr[0]) &&
             $stable(stgValid[LAST]) && $stable(driveSync));

  // R6: a deselected command leaves no valid entry behind
  a_r6_deselect_empty: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !selected) |=> !stgValid[0]);

  // R8: while write data is being taken, the bus is not driven
  a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWrite |-> !driveSync);

  // R8: a write command never turns the drive on one edge later
  a_r8_write_slot_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (advance && stgValid[0] && stgWrite[0]) |=> !driveSync);

endmodule

// File: rtl/nturn_sram_dp.sv
module nturn_sram_dp
  import nturn_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sramStrobe_t             strobe,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES-1:0]        wrMask,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] outReg;

  assign rdWord = mem[rdAddr];

  // Per-lane choice between pending write data and the array word
  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (strobe.fwdHit && wrMask[l]) ?
      wrData[l*LANE_W +: LANE_W] : rdWord[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.commitWrite) begin
      for (int l = 0; l < LANES; l++) begin
        if (wrMask[l]) mem[wrAddr][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                outReg <= '0;
    else if (strobe.loadRead) outReg <= merged;
  end

  assign rdData = outReg;

  // R9: the output register only moves on a read load
  a_r9_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadRead |=> $stable(outReg));

  // R10: an enabled lane of a matching pending write reaches the output
  a_r10_forward_lane0: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRead && strobe.fwdHit && wrMask[0]) |=>
      outReg[LANE_W-1:0] == $past(wrData[LANE_W-1:0]));

endmodule

// File: rtl/nturn_sram.sv
module nturn_sram
  import nturn_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cenN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    weN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        byteWeN,
  input  logic                    oeN,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  sramStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [LANES-1:0]  wrMask;
  logic              driveSync;

  nturn_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
    .clk(clk), .rstN(rstN), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .weN(weN), .addr(addr), .byteWeN(byteWeN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrMask(wrMask), .driveSync(driveSync)
  );

  nturn_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrMask(wrMask), .wrData(wrData), .rdData(rdData)
  );

  // R11: output enable gates the synchronous drive combinationally
  assign rdDrive = driveSync && !oeN;

endmodule

// File: tb/test_nturn_sram.sv
`timescale 1ns/1ps
module test_nturn_sram;

  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN, cenN, ce1N, ce2, ce3N, weN, oeN;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  byteWeN;
  logic [DATA_W-1:0] wrData, rdData;
  logic rdDrive;

  int nChecks = 0;
  int nFail   = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  nturn_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_nturn_sram (
    .clk(clk), .rstN(rstN), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .weN(weN), .addr(addr), .byteWeN(byteWeN), .oeN(oeN), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  // Behavioural reference: memory plus the last two accepted commands
  logic [DATA_W-1:0] refMem [DEPTH];
  bit                hValid [2];
  bit                hWrite [2];
  int                hAddr  [2];
  logic [LANES-1:0]  hMaskN [2];
  bit                expDrive;
  logic [DATA_W-1:0] expData;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
      for (int s = 0; s < 2; s++) begin
        hValid[s] = 0; hWrite[s] = 0; hAddr[s] = 0; hMaskN[s] = '1;
      end
      expDrive = 0;
      expData  = '0;
    end else if (!cenN) begin
      // the command two accepted edges back takes its data now
      if (hValid[1] && hWrite[1])
        for (int l = 0; l < LANES; l++)
          if (!hMaskN[1][l]) refMem[hAddr[1]][l*LANE_W +: LANE_W] = wrData[l*LANE_W +: LANE_W];
      // the command one accepted edge back is returned now
      expDrive = hValid[0] && !hWrite[0];
      if (expDrive) expData = refMem[hAddr[0]];
      hValid[1] = hValid[0]; hWrite[1] = hWrite[0];
      hAddr[1]  = hAddr[0];  hMaskN[1] = hMaskN[0];
      hValid[0] = !ce1N && ce2 && !ce3N;
      hWrite[0] = !weN;
      hAddr[0]  = int'(addr);
      hMaskN[0] = byteWeN;
    end
  end

  task automatic checkNow();
    bit e;
    e = expDrive && !oeN;
    nChecks++;
    if (rdDrive !== e) begin
      nFail++;
      $display("FAIL %s rdDrive actual=%0b expected=%0b", curReq, rdDrive, e);
    end else if (e && rdData !== expData) begin
      nFail++;
      $display("FAIL %s rdData actual=%h expected=%h", curReq, rdData, expData);
    end
  endtask

  function automatic logic [DATA_W-1:0] rndWord();
    logic [63:0] t;
    t = {$urandom, $urandom};
    return t[DATA_W-1:0];
  endfunction

  // One cycle: check the previous edge's result, then set new inputs
  task automatic cyc(input bit sel, input bit wr, input int a,
                     input logic [LANES-1:0] bwN, input bit stall);
    @(negedge clk);
    checkNow();
    cenN    = stall;
    ce1N    = !sel ? 1'($urandom) : 1'b0;
    ce2     = 1'b1;
    ce3N    = 1'b0;
    if (!sel && !ce1N) ce2 = 1'b0;
    weN     = !wr;
    addr    = ADDR_W'(a);
    byteWeN = bwN;
    wrData  = rndWord();
  endtask

  initial begin
    rstN = 0; cenN = 1; ce1N = 1; ce2 = 0; ce3N = 1; weN = 1; oeN = 0;
    addr = '0; byteWeN = '1; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state, drive off and every word reads back zero
    curReq = "R1";
    for (int a = 0; a < DEPTH; a++) cyc(1, 0, a, '1, 0);
    cyc(0, 0, 0, '1, 0);
    cyc(0, 0, 0, '1, 0);

    // R3 R4: full writes, then reads
    curReq = "R3/R4";
    for (int a = 0; a < DEPTH; a++) cyc(1, 1, a, '0, 0);
    for (int a = 0; a < DEPTH; a++) cyc(1, 0, a, '1, 0);

    // R10 R7: alternate write and read to one address back to back
    curReq = "R10";
    for (int i = 0; i < 40; i++) cyc(1, i % 2 == 0, 5, (i % 4 == 0) ? 4'b0000 : 4'b0101, 0);

    // R5: random byte masks with reads
    curReq = "R5";
    for (int i = 0; i < 200; i++) cyc(1, $urandom % 2, $urandom % 4, LANES'($urandom), 0);

    // R6 R8: random deselects between commands
    curReq = "R6/R8";
    for (int i = 0; i < 300; i++)
      cyc($urandom % 3 != 0, $urandom % 2, $urandom % 4, LANES'($urandom), 0);

    // R9: random clock-enable stalls, wrData changes while stalled
    curReq = "R9";
    for (int i = 0; i < 300; i++)
      cyc(1, $urandom % 2, $urandom % 4, LANES'($urandom), $urandom % 3 == 0);

    // R11: output enable toggling, checked right after each change too
    curReq = "R11";
    for (int i = 0; i < 100; i++) begin
      cyc(1, $urandom % 2, $urandom % 4, LANES'($urandom), 0);
      oeN = 1'($urandom);
      #1 checkNow();
    end
    oeN = 0;

    // R2 R7: full random mix of everything
    curReq = "R2/R7";
    for (int i = 0; i < 600; i++)
      cyc($urandom % 5 != 0, $urandom % 2, $urandom % DEPTH, LANES'($urandom), $urandom % 5 == 0);
    cyc(0, 0, 0, '1, 0);
    cyc(0, 0, 0, '1, 0);
    cyc(0, 0, 0, '1, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired during %s", curReq);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule